// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters from a line that several stations share. After a hunt command it can put itself to sleep and throw away traffic that is not meant for it. A two-bit wake-rule input picks how it wakes up again. With the idle rule, the line must stay quiet for one whole character frame. With the flag rule, an extra flag bit on each character marks it as an address; a flagged character wakes the receiver and is delivered. With the filter rule, a flagged character is compared with the station's own address, and only the data after a matching address is delivered. One further encoding turns sleeping off and gives plain reception.

A baud tick at 16 times the bit rate drives the bit timing. A falling edge starts a character, and the start bit is accepted only if the line is still low half a bit later. Every later bit is sampled in the middle of its period. A frame is sent in this order: start bit (0), data bits with the least significant bit first (7 or 8 of them), the address flag (only in the flag and filter rules), an optional even parity bit, and a stop bit (1). Each accepted character comes out as a one-cycle `rx_valid` pulse with its byte and an address marker. Framing and parity error strobes are asserted in that same cycle.

Top module: `mdrop_uart_rx`

## Requirements
- R1: Data bits are taken least significant bit first. `char8`=1 gives 8 data bits. `char8`=0 gives 7 data bits, and `rx_data[7]` is then 0.
- R2: A low pulse on the line that ends before the middle of the start bit (shorter than half a bit) does not start a character, and no `rx_valid` follows.
- R3: If the stop bit of a delivered character is sampled as 0, `frame_err` is 1 in the cycle where `rx_valid` is 1.
- R4: With `par_en`=1, the parity bit makes the count of ones even. That count covers the data bits, the flag bit when one is present, and the parity bit itself. A mismatch sets `par_err` together with `rx_valid`. With `par_en`=0, `par_err` stays 0.
- R5: With `wake_mode`=2'b10, every character is delivered with `rx_is_addr`=0, and `hunt` has no effect.
- R6: With `wake_mode`=2'b00, `hunt` puts the receiver to sleep and characters are dropped. It wakes after the line has been idle for at least one frame length in bit times. The frame length is 2 + data bits + parity bit.
- R7: With `wake_mode`=2'b01, `hunt` puts the receiver to sleep. A character whose flag bit is 1 wakes it and is delivered with `rx_is_addr`=1. While asleep, characters whose flag bit is 0 are dropped.
- R8: With `wake_mode`=2'b01 and the receiver awake, every character is delivered, and `rx_is_addr` equals its flag bit.
- R9: With `wake_mode`=2'b11, flagged characters are never delivered. A flagged character equal to `local_addr` (zero-extended) wakes the receiver. Any other flagged character puts it to sleep. Unflagged characters are delivered only while it is awake.
- R10: After reset the receiver is awake, and `rx_valid`, `frame_err` and `par_err` are 0.
- R11: `rx_valid` lasts one cycle per character. The error strobes are never asserted without `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line; idles high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wake_mode | input | 2 | 00 idle rule, 01 flag rule, 10 plain, 11 address filter |
| char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Even parity bit present |
| local_addr | input | 8 | Station address used by the filter rule |
| hunt | input | 1 | One-cycle command that puts the receiver to sleep |
| rx_valid | output | 1 | Character delivered |
| rx_data | output | 8 | Delivered character |
| rx_is_addr | output | 1 | Delivered character is an address |
| frame_err | output | 1 | Stop bit was low |
| par_err | output | 1 | Parity mismatch |

## Verification
The assertions assume that `wake_mode`, `char8` and `par_en` stay fixed while characters are arriving, and that only one character finishes at a time. The bench changes these settings only while reset is held. It keeps gaps either well below or well above the idle frame length, so the expected wakeup never depends on a single tick. After a bad stop bit it also waits two idle bits, so the spurious start the low line causes ends before the next frame.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;
    typedef enum logic [1:0] {
        WK_IDLE   = 2'b00,
        WK_FLAG   = 2'b01,
        WK_PLAIN  = 2'b10,
        WK_FILTER = 2'b11
    } wake_mode_e;

    typedef enum logic [1:0] {
        SM_IDLE,
        SM_START,
        SM_BITS,
        SM_STOP
    } smp_st_e;
endpackage

// File: rtl/mdrx_sampler.sv
module mdrx_sampler
    import mdrx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              char8,
    input  logic              par_en,
    input  logic              flag_en,
    input  logic              hunt,
    output logic              c_vld,
    output logic [DATA_W-1:0] c_data,
    output logic              c_flag,
    output logic              c_ferr,
    output logic              c_perr,
    output logic              idle_run
);
    localparam int CW   = $clog2(OVS);
    localparam int SR_W = DATA_W + 2;
    localparam int BW   = $clog2(SR_W + 1);
    localparam int IW   = $clog2(SR_W + 3) + 1;

    typedef struct packed {
        logic              sy1;
        logic              sy2;
        smp_st_e           st;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     idx;
        logic [SR_W-1:0]   sr;
        logic [CW-1:0]     icnt;
        logic [IW-1:0]     ibits;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              ferr;
        logic              perr;
    } smp_t;

    smp_t q, d;

    logic [BW-1:0]     n_data;
    logic [BW-1:0]     n_bits;
    logic [IW-1:0]     f_bits;
    logic              line;
    logic [DATA_W-1:0] masked;
    logic              flag_v;
    logic              xsum;

    always_comb begin
        n_data = char8 ? BW'(DATA_W) : BW'(DATA_W - 1);
        n_bits = n_data + BW'(flag_en) + BW'(par_en);
        f_bits = IW'(n_bits) + IW'(2);
        line   = q.sy2;

        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = (BW'(i) < n_data) ? q.sr[i] : 1'b0;
        end
        flag_v = flag_en ? q.sr[n_data] : 1'b0;
        xsum   = (^masked) ^ flag_v ^ q.sr[n_data + BW'(flag_en)];

        d     = q;
        d.sy1 = rx_line;
        d.sy2 = q.sy1;
        d.vld = 1'b0;

        case (q.st)
            SM_IDLE: begin
                if (baud_tick) begin
                    if (!line) begin
                        d.st    = SM_START;
                        d.cnt   = '0;
                        d.icnt  = '0;
                        d.ibits = '0;
                    end else begin
                        d.icnt = q.icnt + CW'(1);
                        if (q.icnt == CW'(OVS - 1) && q.ibits != '1) begin
                            d.ibits = q.ibits + IW'(1);
                        end
                    end
                end
            end
            SM_START: begin
                if (baud_tick) begin
                    if (q.cnt == CW'(OVS / 2 - 1)) begin
                        d.cnt = '0;
                        if (!line) begin
                            d.st  = SM_BITS;
                            d.idx = '0;
                            d.sr  = '0;
                        end else begin
                            d.st = SM_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            SM_BITS: begin
                if (baud_tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt       = '0;
                        d.sr[q.idx] = line;
                        if (q.idx == n_bits - BW'(1)) begin
                            d.st = SM_STOP;
                        end else begin
                            d.idx = q.idx + BW'(1);
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            default: begin
                if (baud_tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.st    = SM_IDLE;
                        d.cnt   = '0;
                        d.icnt  = '0;
                        d.ibits = '0;
                        d.vld   = 1'b1;
                        d.data  = masked;
                        d.flag  = flag_v;
                        d.ferr  = !line;
                        d.perr  = par_en && xsum;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
        endcase

        if (hunt) begin
            d.icnt  = '0;
            d.ibits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sy1   <= 1'b1;
            q.sy2   <= 1'b1;
            q.st    <= SM_IDLE;
        end else begin
            q <= d;
        end
    end

    assign c_vld    = q.vld;
    assign c_data   = q.data;
    assign c_flag   = q.flag;
    assign c_ferr   = q.ferr;
    assign c_perr   = q.perr;
    assign idle_run = (q.st == SM_IDLE) && (q.ibits >= f_bits);

    a_r2_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(q.st));

    a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SM_BITS) |-> (q.idx < n_bits));

    a_r11_char_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |=> !c_vld);
endmodule

// File: rtl/mdrx_wake.sv
module mdrx_wake
    import mdrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wake_mode,
    input  logic              hunt,
    input  logic              idle_run,
    input  logic [DATA_W-1:0] local_addr,
    input  logic              c_vld,
    input  logic [DATA_W-1:0] c_data,
    input  logic              c_flag,
    input  logic              c_ferr,
    input  logic              c_perr,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_is_addr,
    output logic              frame_err,
    output logic              par_err
);
    typedef struct packed {
        logic              asleep;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              is_addr;
        logic              ferr;
        logic              perr;
    } wk_t;

    wk_t q, d;
    wake_mode_e md;
    logic take;
    logic as_addr;

    always_comb begin
        md      = wake_mode_e'(wake_mode);
        d       = q;
        d.vld   = 1'b0;
        d.ferr  = 1'b0;
        d.perr  = 1'b0;
        take    = 1'b0;
        as_addr = 1'b0;

        case (md)
            WK_PLAIN: begin
                d.asleep = 1'b0;
                take     = c_vld;
            end
            WK_IDLE: begin
                if (q.asleep) begin
                    if (idle_run) d.asleep = 1'b0;
                end else begin
                    take = c_vld;
                end
            end
            WK_FLAG: begin
                if (c_vld) begin
                    if (c_flag) begin
                        take     = 1'b1;
                        as_addr  = 1'b1;
                        d.asleep = 1'b0;
                    end else begin
                        take = !q.asleep;
                    end
                end
            end
            default: begin
                if (c_vld) begin
                    if (c_flag) begin
                        d.asleep = (c_data != local_addr);
                    end else begin
                        take = !q.asleep;
                    end
                end
            end
        endcase

        if (hunt && md != WK_PLAIN) begin
            d.asleep = 1'b1;
            take     = 1'b0;
        end

        if (take) begin
            d.vld     = 1'b1;
            d.data    = c_data;
            d.is_addr = as_addr;
            d.ferr    = c_ferr;
            d.perr    = c_perr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_valid   = q.vld;
    assign rx_data    = q.data;
    assign rx_is_addr = q.is_addr;
    assign frame_err  = q.ferr;
    assign par_err    = q.perr;

    a_r6_hunt_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt && wake_mode != 2'b10) |=> q.asleep);

    a_r5_plain_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mode == 2'b10 && $past(wake_mode) == 2'b10) |-> !q.asleep);

    a_r7_data_stays_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (q.asleep && wake_mode == 2'b01 && c_vld && !c_flag && !hunt) |=> !rx_valid);

    a_r9_no_addr_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && wake_mode == 2'b11 && $past(wake_mode) == 2'b11) |-> !rx_is_addr);

    a_r11_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err || par_err) |-> rx_valid);

    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
    import mdrx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic [1:0]        wake_mode,
    input  logic              char8,
    input  logic              par_en,
    input  logic [DATA_W-1:0] local_addr,
    input  logic              hunt,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_is_addr,
    output logic              frame_err,
    output logic              par_err
);
    logic              c_vld;
    logic [DATA_W-1:0] c_data;
    logic              c_flag;
    logic              c_ferr;
    logic              c_perr;
    logic              idle_run;
    logic              flag_en;

    assign flag_en = wake_mode[0];

    mdrx_sampler #(.OVS(OVS), .DATA_W(DATA_W)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .baud_tick (baud_tick),
        .char8     (char8),
        .par_en    (par_en),
        .flag_en   (flag_en),
        .hunt      (hunt),
        .c_vld     (c_vld),
        .c_data    (c_data),
        .c_flag    (c_flag),
        .c_ferr    (c_ferr),
        .c_perr    (c_perr),
        .idle_run  (idle_run)
    );

    mdrx_wake #(.DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_mode  (wake_mode),
        .hunt       (hunt),
        .idle_run   (idle_run),
        .local_addr (local_addr),
        .c_vld      (c_vld),
        .c_data     (c_data),
        .c_flag     (c_flag),
        .c_ferr     (c_ferr),
        .c_perr     (c_perr),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_is_addr (rx_is_addr),
        .frame_err  (frame_err),
        .par_err    (par_err)
    );
endmodule

// File: tb/sim_mdrop_uart_rx.sv
module sim_mdrop_uart_rx;
    localparam int CLK_P   = 10;
    localparam int BIT_CLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       char8 = 1'b1;
    logic       par_en = 1'b0;
    logic [7:0] laddr = 8'h5A;
    logic       hunt = 1'b0;
    logic       rx_valid, rx_is_addr, frame_err, par_err;
    logic [7:0] rx_data;

    int tests = 0;
    int fails = 0;
    int vcount = 0;
    logic [7:0] l_data;
    logic l_addr, l_ferr, l_perr;
    bit m_asleep;
    int run;
    bit finished = 0;

    mdrop_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .baud_tick(tick),
        .wake_mode(mode), .char8(char8), .par_en(par_en), .local_addr(laddr),
        .hunt(hunt), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_addr(rx_is_addr), .frame_err(frame_err), .par_err(par_err)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                vcount++;
                l_data = rx_data;
                l_addr = rx_is_addr;
                l_ferr = frame_err;
                l_perr = par_err;
            end
            if ((frame_err || par_err) && !rx_valid) begin
                tests++;
                fails++;
                $display("FAIL R11 error strobe without valid: actual=%0b%0b expected=00", frame_err, par_err);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ndata();
        return char8 ? 8 : 7;
    endfunction

    function automatic int fbits();
        return 2 + ndata() + int'(mode[0]) + int'(par_en);
    endfunction

    function automatic string mtag();
        case (mode)
            2'b00: return "R6";
            2'b01: return "R7";
            2'b10: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic bit_out(input logic v);
        rx = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic gap(input int g);
        rx = 1'b1;
        repeat (g * BIT_CLK) @(negedge clk);
        run += g;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic c8, input logic pe);
        @(negedge clk);
        rst_n = 1'b0;
        mode = m;
        char8 = c8;
        par_en = pe;
        rx = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        m_asleep = 0;
        run = 0;
    endtask

    task automatic do_hunt();
        @(negedge clk);
        hunt = 1'b1;
        @(negedge clk);
        hunt = 1'b0;
        if (mode != 2'b10) m_asleep = 1;
        run = 0;
    endtask

    task automatic send(input logic [7:0] d, input logic ab, input logic bpar, input logic bstop);
        logic [7:0] md;
        logic abe, p;
        bit exp_v, exp_a;
        int c0;
        md = char8 ? d : {1'b0, d[6:0]};
        abe = mode[0] ? ab : 1'b0;
        if (mode == 2'b00 && m_asleep && run >= fbits()) m_asleep = 0;
        exp_v = 0;
        exp_a = 0;
        case (mode)
            2'b10: exp_v = 1;
            2'b00: exp_v = !m_asleep;
            2'b01: begin
                if (abe) begin
                    exp_v = 1;
                    exp_a = 1;
                    m_asleep = 0;
                end else begin
                    exp_v = !m_asleep;
                end
            end
            default: begin
                if (abe) m_asleep = (md != laddr);
                else exp_v = !m_asleep;
            end
        endcase
        p = (^md) ^ abe;
        c0 = vcount;
        bit_out(1'b0);
        for (int i = 0; i < ndata(); i++) bit_out(d[i]);
        if (mode[0]) bit_out(ab);
        if (par_en) bit_out(p ^ bpar);
        bit_out(!bstop);
        rx = 1'b1;
        chk((vcount - c0) == int'(exp_v), {mtag(), " delivery count"}, vcount - c0, int'(exp_v));
        if (exp_v && (vcount - c0) == 1) begin
            chk(l_data == md, "R1 data", l_data, md);
            chk(l_addr == exp_a, mode == 2'b01 ? "R8 address marker" : "R5 address marker", l_addr, exp_a);
            chk(l_ferr == bstop, "R3 framing strobe", l_ferr, bstop);
            chk(l_perr == (bpar && par_en), "R4 parity strobe", l_perr, bpar && par_en);
        end
        if (bstop) begin
            repeat (2 * BIT_CLK) @(negedge clk);
        end
        run = 0;
    endtask

    initial begin
        void'($urandom(32'h0BAD_5EED));
        do_reset(2'b10, 1'b1, 1'b0);
        // R10 reset state
        chk(rx_valid == 0, "R10 rx_valid after reset", rx_valid, 0);
        chk(frame_err == 0 && par_err == 0, "R10 strobes after reset", {frame_err, par_err}, 0);
        gap(2);

        // R5 and R1 plain reception, hunt ignored
        send(8'hA5, 0, 0, 0);
        do_hunt();
        gap(1);
        send(8'h3C, 0, 0, 0);
        do_reset(2'b10, 1'b0, 1'b0);
        gap(2);
        send(8'hFF, 0, 0, 0);

        // R2 short low glitch
        begin
            int c0;
            c0 = vcount;
            rx = 1'b0;
            repeat (8) @(negedge clk);
            rx = 1'b1;
            gap(3);
            chk(vcount == c0, "R2 glitch ignored", vcount - c0, 0);
            send(8'h41, 0, 0, 0);
        end

        // R4 and R3
        do_reset(2'b10, 1'b1, 1'b1);
        gap(2);
        send(8'h96, 0, 0, 0);
        gap(1);
        send(8'h96, 0, 1, 0);
        gap(1);
        send(8'h17, 0, 0, 1);

        // R6 idle-line wakeup
        do_reset(2'b00, 1'b1, 1'b0);
        gap(2);
        send(8'h11, 0, 0, 0);
        do_hunt();
        send(8'h22, 0, 0, 0);
        send(8'h23, 0, 0, 0);
        gap(fbits() - 2);
        send(8'h24, 0, 0, 0);
        gap(fbits() + 2);
        send(8'h25, 0, 0, 0);

        // R7 and R8 flag wakeup
        do_reset(2'b01, 1'b1, 1'b0);
        gap(2);
        do_hunt();
        gap(1);
        send(8'h10, 0, 0, 0);
        send(8'h33, 1, 0, 0);
        send(8'h44, 0, 0, 0);
        send(8'h55, 1, 0, 0);

        // R9 address filter
        do_reset(2'b11, 1'b1, 1'b1);
        gap(2);
        do_hunt();
        gap(1);
        send(8'h11, 1, 0, 0);
        send(8'h66, 0, 0, 0);
        send(laddr, 1, 0, 0);
        send(8'h42, 0, 0, 0);
        send(8'h11, 1, 0, 0);
        send(8'h43, 0, 0, 0);

        // random mix per mode
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m), 1'($urandom % 2), 1'($urandom % 2));
            gap(2);
            for (int k = 0; k < 30; k++) begin
                logic [7:0] d;
                logic ab, bp, bs;
                int g;
                if ($urandom % 6 == 0) do_hunt();
                g = $urandom % 3;
                gap(g == 2 ? fbits() + 2 : g);
                d = ($urandom % 4 == 0) ? laddr : 8'($urandom);
                ab = ($urandom % 3 == 0);
                bp = par_en && ($urandom % 8 == 0);
                bs = ($urandom % 10 == 0);
                send(d, ab, bp, bs);
            end
        end

        gap(2);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule